// File: doc/BRIEF.md
# Split-Transaction Atomic Read-Modify-Write Unit

This block executes atomic operations on 32-bit memory words as split transactions. An atomic request carries an opcode, a byte address, an operand, a compare value, a caller tag and a flag that says whether the old value should come back. The unit places the request in one of a few tracking slots and reads the target word from memory. Memory may take many cycles to answer. When the data arrives, the unit computes the new word in its own ALU and writes it back. Sub-word byte stores that need merging into a word also go through this unit, as a read-modify-write.

Requests that want no return value cost one read and one write, and several of them can be in flight at once. A request that wants its value back costs four memory operations: a read of the target, a write of the old value to a per-slot scratch word, a read of that scratch word, and finally the write of the new value to the target. Every request ends with one response pulse carrying its tag. When a value was requested, the response also carries the word read back from scratch.

Two requests to the same word never overlap. A later request waits in its slot until every earlier request to that word has finished. Requests to different words proceed independently. Memory commands are tagged with the slot number, and memory answers carry that tag back, so memory may answer out of order.

Top module: `atomic_rmw_unit`

## Requirements
- R1: `reqReady` is low exactly when all NUM_SLOTS tracking slots are occupied. A slot frees on the clock edge that consumes its final memory acknowledgement.
- R2: The first memory command of every request is a read (`memCmdWrite`=0) of its target word address, which is `reqAddr[ADDR_W-1:2]`. The target is not written before that read is acknowledged.
- R3: A request with `reqRet`=0 issues exactly two commands: a read of the target, then a write of the new word to the target. Its response carries `respData`=0.
- R4: A request with `reqRet`=1 issues exactly four commands, in this order: read target; write the old word to scratch word SCRATCH_WORD+slot; read that scratch word; write the new word to the target. Its `respData` is the scratch read data, which is the pre-modification word.
- R5: `respValid` pulses for one cycle, in the cycle after the edge that consumes the acknowledgement of a request's final command. It carries that request's `reqTag`.
- R6: The new word for opcode `reqOp` is: 0 old+operand (wrapping); 1 signed minimum; 2 signed maximum; 3 AND; 4 OR; 5 XOR; 6 operand (exchange). Codes 9 to 15 leave the word unchanged.
- R7: Opcode 7 (compare-exchange) writes the operand when the old word equals `reqCompare`, and writes the old word back otherwise.
- R8: Opcode 8 (byte store) replaces byte lane `reqAddr[1:0]` (lane 0 = bits 7:0) of the old word with `reqOperand[7:0]` and keeps the other three bytes.
- R9: A request whose word address matches a still-busy earlier request issues no memory command until all such earlier requests have completed. Same-word operations therefore take effect in acceptance order.
- R10: Requests to different words overlap, so more than one target read can be outstanding at once.
- R11: While `memCmdValid` is high and `memCmdReady` is low, the command (valid, write, address, data) stays unchanged in the next cycle.
- R12: During and right after reset, `reqReady`=1, `memCmdValid`=0 and `respValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Atomic request valid |
| reqReady | output | 1 | A tracking slot is free |
| reqOp | input | 4 | Operation code |
| reqAddr | input | ADDR_W | Byte address |
| reqOperand | input | 32 | Operand |
| reqCompare | input | 32 | Compare value for compare-exchange |
| reqRet | input | 1 | Return the pre-modification word |
| reqTag | input | TAG_W | Caller tag echoed in the response |
| memCmdValid | output | 1 | Memory command valid |
| memCmdReady | input | 1 | Memory accepts the command |
| memCmdWrite | output | 1 | 1 write, 0 read |
| memCmdAddr | output | ADDR_W-2 | Word address |
| memCmdData | output | 32 | Write data |
| memCmdTag | output | $clog2(NUM_SLOTS) | Slot issuing the command |
| memRspValid | input | 1 | Memory acknowledgement |
| memRspTag | input | $clog2(NUM_SLOTS) | Slot being acknowledged |
| memRspData | input | 32 | Read data (ignored for writes) |
| respValid | output | 1 | Request completed |
| respTag | output | TAG_W | Tag of the completed request |
| respData | output | 32 | Old word, or 0 when none was requested |

## Verification
Each operation code is first applied on its own to a distinct word with known contents. The compare-exchange case runs once with a matching compare value and once with a mismatching one, and the byte store is applied on two different lanes; these runs separate wrong ALU results from sequencing faults. A burst of value-returning adds to one word shows whether the returned old values climb in acceptance order, which would break if the same-word wait failed. Long memory latency with several different words shows that target reads overlap, and holding memory stalled shows both the full-slot back-pressure and a command that stays steady. A long random mix of operations, return flags, lanes and out-of-order memory latencies is then checked against a bench model of every word, every returned value and the total command count.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

  localparam logic [3:0] OPC_ADD  = 4'd0;
  localparam logic [3:0] OPC_MIN  = 4'd1;
  localparam logic [3:0] OPC_MAX  = 4'd2;
  localparam logic [3:0] OPC_AND  = 4'd3;
  localparam logic [3:0] OPC_OR   = 4'd4;
  localparam logic [3:0] OPC_XOR  = 4'd5;
  localparam logic [3:0] OPC_SWAP = 4'd6;
  localparam logic [3:0] OPC_CAS  = 4'd7;
  localparam logic [3:0] OPC_BYTE = 4'd8;

  // which memory command the selected slot issues
  typedef enum logic [1:0] {
    KIND_TGT_RD = 2'd0,
    KIND_SCR_WR = 2'd1,
    KIND_SCR_RD = 2'd2,
    KIND_TGT_WR = 2'd3
  } cmdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     capOld;
    logic     capRet;
    logic     emit;
    logic     emitRet;
    cmdKind_e kind;
  } dpStrobe_t;

  function automatic logic [31:0] applyOp(input logic [3:0] op, input logic [31:0] oldWord,
                                          input logic [31:0] operand, input logic [31:0] cmpWord,
                                          input logic [1:0] lane);
    logic [31:0] merged;
    merged = oldWord;
    merged[int'(lane) * 8 +: 8] = operand[7:0];
    case (op)
      OPC_ADD:  return oldWord + operand;
      OPC_MIN:  return ($signed(oldWord) < $signed(operand)) ? oldWord : operand;
      OPC_MAX:  return ($signed(oldWord) > $signed(operand)) ? oldWord : operand;
      OPC_AND:  return oldWord & operand;
      OPC_OR:   return oldWord | operand;
      OPC_XOR:  return oldWord ^ operand;
      OPC_SWAP: return operand;
      OPC_CAS:  return (oldWord == cmpWord) ? operand : oldWord;
      OPC_BYTE: return merged;
      default:  return oldWord;
    endcase
  endfunction

endpackage

// File: rtl/atomic_ctrl.sv
module atomic_ctrl
  import atomic_pkg::*;
#(
  parameter int NS = 4,
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqRet,
  output logic          reqReady,
  input  logic [NS-1:0] matchVec,
  output logic [SW-1:0] loadSlot,
  output logic [SW-1:0] cmdSlot,
  output dpStrobe_t     strobe,
  output logic          memCmdValid,
  input  logic          memCmdReady,
  output logic          memCmdWrite,
  input  logic          memRspValid,
  input  logic [SW-1:0] memRspTag
);

  logic [NS-1:0]          busy, waiting, retF;
  logic [NS-1:0][1:0]     step;
  logic [NS-1:0][NS-1:0]  blockMask;
  logic                   lockValid;
  logic [SW-1:0]          lockSlot;

  logic [NS-1:0] eligible, doneVec;
  logic [SW-1:0] pickSlot;
  logic          anyEligible, accept, issue, finishing;
  logic [1:0]    lastStep;
  cmdKind_e      kind;

  always_comb begin
    loadSlot = '0;
    for (int i = NS - 1; i >= 0; i--) if (!busy[i]) loadSlot = SW'(i);
    pickSlot = '0;
    for (int i = NS - 1; i >= 0; i--) if (eligible[i]) pickSlot = SW'(i);
  end

  for (genvar g = 0; g < NS; g++) begin : gElig
    assign eligible[g] = busy[g] && !waiting[g] && (blockMask[g] == '0);
  end

  assign reqReady    = ~&busy;
  assign accept      = reqValid && reqReady;
  assign anyEligible = |eligible;
  assign cmdSlot     = lockValid ? lockSlot : pickSlot;
  assign memCmdValid = lockValid || anyEligible;
  assign issue       = memCmdValid && memCmdReady;
  assign lastStep    = retF[memRspTag] ? 2'd3 : 2'd1;
  assign finishing   = memRspValid && (step[memRspTag] == lastStep);
  assign doneVec     = finishing ? (NS'(1) << memRspTag) : '0;

  always_comb begin
    case (step[cmdSlot])
      2'd0:    kind = KIND_TGT_RD;
      2'd1:    kind = retF[cmdSlot] ? KIND_SCR_WR : KIND_TGT_WR;
      2'd2:    kind = KIND_SCR_RD;
      default: kind = KIND_TGT_WR;
    endcase
  end

  assign memCmdWrite     = (kind == KIND_SCR_WR) || (kind == KIND_TGT_WR);
  assign strobe.load     = accept;
  assign strobe.capOld   = memRspValid && (step[memRspTag] == 2'd0);
  assign strobe.capRet   = memRspValid && retF[memRspTag] && (step[memRspTag] == 2'd2);
  assign strobe.emit     = finishing;
  assign strobe.emitRet  = retF[memRspTag];
  assign strobe.kind     = kind;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= '0;
      waiting   <= '0;
      retF      <= '0;
      step      <= '0;
      blockMask <= '0;
      lockValid <= 1'b0;
      lockSlot  <= '0;
    end else begin
      for (int i = 0; i < NS; i++) blockMask[i] <= blockMask[i] & ~doneVec;
      if (issue) waiting[cmdSlot] <= 1'b1;
      if (memRspValid) begin
        waiting[memRspTag] <= 1'b0;
        if (finishing) begin
          busy[memRspTag] <= 1'b0;
          step[memRspTag] <= 2'd0;
        end else begin
          step[memRspTag] <= step[memRspTag] + 2'd1;
        end
      end
      if (accept) begin
        busy[loadSlot]      <= 1'b1;
        waiting[loadSlot]   <= 1'b0;
        retF[loadSlot]      <= reqRet;
        step[loadSlot]      <= 2'd0;
        blockMask[loadSlot] <= matchVec & busy & ~doneVec;
      end
      lockValid <= memCmdValid && !memCmdReady;
      lockSlot  <= cmdSlot;
    end
  end

  // a slot may only rise from full when some request just finished
  assert_free_after_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> $past(memRspValid));

  for (genvar g = 0; g < NS; g++) begin : gOrder
    // a slot still waiting on an older same-word request has not started
    assert_blocked_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
      (busy[g] && (blockMask[g] != '0)) |-> ((step[g] == 2'd0) && !waiting[g]));
  end

endmodule

// File: rtl/atomic_dp.sv
module atomic_dp
  import atomic_pkg::*;
#(
  parameter int          NS           = 4,
  parameter int          ADDR_W       = 16,
  parameter int          TAG_W        = 4,
  parameter int unsigned SCRATCH_WORD = 16368,
  localparam int SW = $clog2(NS),
  localparam int WA = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [SW-1:0]     loadSlot,
  input  logic [SW-1:0]     cmdSlot,
  input  logic [SW-1:0]     rspSlot,
  input  logic [3:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqOperand,
  input  logic [31:0]       reqCompare,
  input  logic [TAG_W-1:0]  reqTag,
  output logic [NS-1:0]     matchVec,
  output logic [WA-1:0]     memCmdAddr,
  output logic [31:0]       memCmdData,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              respValid,
  output logic [TAG_W-1:0]  respTag,
  output logic [31:0]       respData
);

  localparam logic [WA-1:0] SCR_BASE = WA'(SCRATCH_WORD);

  logic [WA-1:0]    sWord    [NS];
  logic [1:0]       sLane    [NS];
  logic [3:0]       sOp      [NS];
  logic [31:0]      sOperand [NS];
  logic [31:0]      sCompare [NS];
  logic [TAG_W-1:0] sTag     [NS];
  logic [31:0]      sOld     [NS];
  logic [31:0]      sRet     [NS];
  logic [31:0]      newWord;

  for (genvar g = 0; g < NS; g++) begin : gMatch
    assign matchVec[g] = (sWord[g] == reqAddr[ADDR_W-1:2]);
  end

  assign newWord = applyOp(sOp[cmdSlot], sOld[cmdSlot], sOperand[cmdSlot],
                           sCompare[cmdSlot], sLane[cmdSlot]);

  always_comb begin
    case (strobe.kind)
      KIND_SCR_WR: begin memCmdAddr = SCR_BASE + WA'(cmdSlot); memCmdData = sOld[cmdSlot]; end
      KIND_SCR_RD: begin memCmdAddr = SCR_BASE + WA'(cmdSlot); memCmdData = '0; end
      KIND_TGT_WR: begin memCmdAddr = sWord[cmdSlot];          memCmdData = newWord; end
      default:     begin memCmdAddr = sWord[cmdSlot];          memCmdData = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NS; i++) sWord[i] <= '0;
    end else if (strobe.load) begin
      sWord[loadSlot]    <= reqAddr[ADDR_W-1:2];
      sLane[loadSlot]    <= reqAddr[1:0];
      sOp[loadSlot]      <= reqOp;
      sOperand[loadSlot] <= reqOperand;
      sCompare[loadSlot] <= reqCompare;
      sTag[loadSlot]     <= reqTag;
    end
    if (strobe.capOld) sOld[rspSlot] <= memRspData;
    if (strobe.capRet) sRet[rspSlot] <= memRspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respTag   <= '0;
      respData  <= '0;
    end else begin
      respValid <= strobe.emit;
      if (strobe.emit) begin
        respTag  <= sTag[rspSlot];
        respData <= strobe.emitRet ? sRet[rspSlot] : 32'd0;
      end
    end
  end

  // a completion is only ever reported right after a memory acknowledgement
  assert_resp_follows_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(memRspValid));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_pkg::*;
#(
  parameter int          NUM_SLOTS    = 4,
  parameter int          ADDR_W       = 16,
  parameter int          TAG_W        = 4,
  parameter int unsigned SCRATCH_WORD = 16368,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqOperand,
  input  logic [31:0]       reqCompare,
  input  logic              reqRet,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              memCmdValid,
  input  logic              memCmdReady,
  output logic              memCmdWrite,
  output logic [ADDR_W-3:0] memCmdAddr,
  output logic [31:0]       memCmdData,
  output logic [SW-1:0]     memCmdTag,
  input  logic              memRspValid,
  input  logic [SW-1:0]     memRspTag,
  input  logic [31:0]       memRspData,
  output logic              respValid,
  output logic [TAG_W-1:0]  respTag,
  output logic [31:0]       respData
);

  dpStrobe_t             strobe;
  logic [NUM_SLOTS-1:0]  matchVec;
  logic [SW-1:0]         loadSlot;

  atomic_ctrl #(.NS(NUM_SLOTS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRet(reqRet), .reqReady(reqReady),
    .matchVec(matchVec), .loadSlot(loadSlot), .cmdSlot(memCmdTag), .strobe(strobe),
    .memCmdValid(memCmdValid), .memCmdReady(memCmdReady), .memCmdWrite(memCmdWrite),
    .memRspValid(memRspValid), .memRspTag(memRspTag)
  );

  atomic_dp #(.NS(NUM_SLOTS), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .SCRATCH_WORD(SCRATCH_WORD)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadSlot(loadSlot), .cmdSlot(memCmdTag),
    .rspSlot(memRspTag), .reqOp(reqOp), .reqAddr(reqAddr), .reqOperand(reqOperand),
    .reqCompare(reqCompare), .reqTag(reqTag), .matchVec(matchVec), .memCmdAddr(memCmdAddr),
    .memCmdData(memCmdData), .memRspValid(memRspValid), .memRspData(memRspData),
    .respValid(respValid), .respTag(respTag), .respData(respData)
  );

  // a stalled command is held steady
  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memCmdValid && !memCmdReady) |=> (memCmdValid && $stable(memCmdWrite) &&
                                       $stable(memCmdAddr) && $stable(memCmdData)));

endmodule

// File: tb/sim_atomic_rmw_unit.sv
`timescale 1ns/1ps
module sim_atomic_rmw_unit;
  localparam int NS = 4, AW = 16, TW = 4, SW = 2, WA = 14, SCR = 48;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, reqRet = 1'b0;
  logic [3:0] reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0] reqOperand = '0, reqCompare = '0;
  logic [TW-1:0] reqTag = '0;
  logic memCmdValid, memCmdReady = 1'b0, memCmdWrite;
  logic [WA-1:0] memCmdAddr;
  logic [31:0] memCmdData;
  logic [SW-1:0] memCmdTag;
  logic memRspValid = 1'b0;
  logic [SW-1:0] memRspTag = '0;
  logic [31:0] memRspData = '0;
  logic respValid;
  logic [TW-1:0] respTag;
  logic [31:0] respData;

  atomic_rmw_unit #(.NUM_SLOTS(NS), .ADDR_W(AW), .TAG_W(TW), .SCRATCH_WORD(SCR)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqOperand(reqOperand), .reqCompare(reqCompare), .reqRet(reqRet),
    .reqTag(reqTag), .memCmdValid(memCmdValid), .memCmdReady(memCmdReady),
    .memCmdWrite(memCmdWrite), .memCmdAddr(memCmdAddr), .memCmdData(memCmdData),
    .memCmdTag(memCmdTag), .memRspValid(memRspValid), .memRspTag(memRspTag),
    .memRspData(memRspData), .respValid(respValid), .respTag(respTag), .respData(respData));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refOp(input logic [3:0] op, input logic [31:0] oldW,
                                        input logic [31:0] opnd, input logic [31:0] cmpW,
                                        input logic [1:0] lane);
    logic [31:0] r;
    r = oldW;
    case (op)
      4'd0: r = oldW + opnd;
      4'd1: r = ($signed(opnd) < $signed(oldW)) ? opnd : oldW;
      4'd2: r = ($signed(opnd) > $signed(oldW)) ? opnd : oldW;
      4'd3: r = oldW & opnd;
      4'd4: r = oldW | opnd;
      4'd5: r = oldW ^ opnd;
      4'd6: r = opnd;
      4'd7: r = (cmpW == oldW) ? opnd : oldW;
      4'd8: r[lane*8 +: 8] = opnd[7:0];
      default: r = oldW;
    endcase
    return r;
  endfunction

  typedef struct packed { logic [3:0] op; logic [AW-1:0] addr; logic [31:0] opnd; logic [31:0] cmp; logic ret; } req_t;
  typedef struct packed { logic [SW-1:0] tag; logic [31:0] data; logic fin; logic isRd; int dly; } rsp_t;

  req_t reqQ[$];
  rsp_t rspQ[$];
  logic [31:0] mem [0:63];
  logic [31:0] refMem [0:63];
  logic [31:0] expData [0:15];
  bit tagBusy [0:15];
  int outstanding = 0, nCmd = 0, nRet = 0, nNoRet = 0, readsOut = 0, maxReadsOut = 0;
  int slotStep [NS];
  logic [WA-1:0] slotTgt [NS];
  bit stallMem = 0, expectResp = 0, reqFired = 0, prevStall = 0;
  int maxLat = 6;
  logic [WA-1:0] prevAddr;
  logic [31:0] prevData;

  task automatic pushReq(input logic [3:0] op, input logic [AW-1:0] addr, input logic [31:0] opnd,
                         input logic [31:0] cmp, input logic ret);
    req_t r;
    r.op = op; r.addr = addr; r.opnd = opnd; r.cmp = cmp; r.ret = ret;
    reqQ.push_back(r);
  endtask

  task automatic drain();
    while (reqQ.size() != 0 || outstanding != 0 || reqValid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // requester and memory model, all driven away from the rising edge
  initial begin
    for (int s = 0; s < NS; s++) slotStep[s] = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (expectResp || respValid) begin
          chk(respValid === expectResp, "R5 response one cycle after final ack", {31'd0, respValid}, {31'd0, expectResp});
          if (respValid) begin
            if (!tagBusy[respTag]) chk(1'b0, "R5 response tag not outstanding", {28'd0, respTag}, 32'd0);
            else begin
              chk(respData === expData[respTag], "R3/R4 response data", respData, expData[respTag]);
              tagBusy[respTag] = 0;
              outstanding--;
            end
          end
        end
        expectResp = 0;
        if (reqFired) begin reqValid = 1'b0; reqFired = 0; end
        memRspValid = 1'b0;
        for (int i = 0; i < rspQ.size(); i++) rspQ[i].dly = rspQ[i].dly - 1;
        for (int i = 0; i < rspQ.size(); i++) begin
          if (rspQ[i].dly <= 0 && !memRspValid) begin
            memRspValid = 1'b1;
            memRspTag = rspQ[i].tag;
            memRspData = rspQ[i].data;
            if (rspQ[i].fin) expectResp = 1;
            if (rspQ[i].isRd) readsOut--;
            rspQ.delete(i);
          end
        end
        memCmdReady = stallMem ? 1'b0 : (($urandom % 4) != 0);
        if (!reqValid && reqQ.size() != 0) begin
          req_t r;
          r = reqQ.pop_front();
          reqOp = r.op; reqAddr = r.addr; reqOperand = r.opnd; reqCompare = r.cmp; reqRet = r.ret;
          for (int t = 15; t >= 0; t--) if (!tagBusy[t]) reqTag = TW'(t);
          reqValid = 1'b1;
        end
        #1;
        if (prevStall) begin
          chk(memCmdValid === 1'b1 && memCmdAddr === prevAddr && memCmdData === prevData,
              "R11 stalled command held", {18'd0, memCmdAddr}, {18'd0, prevAddr});
        end
        prevStall = memCmdValid && !memCmdReady;
        prevAddr = memCmdAddr;
        prevData = memCmdData;
        if (reqValid && reqReady) begin
          logic [5:0] w;
          w = reqAddr[7:2];
          expData[reqTag] = reqRet ? refMem[w] : 32'd0;
          refMem[w] = refOp(reqOp, refMem[w], reqOperand, reqCompare, reqAddr[1:0]);
          tagBusy[reqTag] = 1;
          outstanding++;
          if (reqRet) nRet++; else nNoRet++;
          reqFired = 1;
        end
        if (memCmdValid && memCmdReady) begin
          rsp_t e;
          int s;
          logic [WA-1:0] scr;
          s = int'(memCmdTag);
          scr = WA'(SCR + s);
          nCmd++;
          e.tag = memCmdTag; e.fin = 1'b0; e.isRd = 1'b0; e.dly = 1 + int'($urandom % maxLat);
          case (slotStep[s])
            0: begin
              chk(!memCmdWrite && memCmdAddr != scr, "R2 first command reads target", {31'd0, memCmdWrite}, 32'd0);
              slotTgt[s] = memCmdAddr; slotStep[s] = 1; e.isRd = 1'b1; readsOut++;
              if (readsOut > maxReadsOut) maxReadsOut = readsOut;
            end
            1: begin
              if (memCmdWrite && memCmdAddr == scr) begin
                chk(memCmdData === mem[slotTgt[s][5:0]], "R4 scratch write holds old word", memCmdData, mem[slotTgt[s][5:0]]);
                slotStep[s] = 2;
              end else begin
                chk(memCmdWrite && memCmdAddr == slotTgt[s], "R3 second command writes target", {18'd0, memCmdAddr}, {18'd0, slotTgt[s]});
                e.fin = 1'b1; slotStep[s] = 0;
              end
            end
            2: begin
              chk(!memCmdWrite && memCmdAddr == scr, "R4 third command reads scratch", {18'd0, memCmdAddr}, {18'd0, scr});
              slotStep[s] = 3;
            end
            default: begin
              chk(memCmdWrite && memCmdAddr == slotTgt[s], "R4 fourth command writes target", {18'd0, memCmdAddr}, {18'd0, slotTgt[s]});
              e.fin = 1'b1; slotStep[s] = 0;
            end
          endcase
          e.data = mem[memCmdAddr[5:0]];
          if (memCmdWrite) mem[memCmdAddr[5:0]] = memCmdData;
          rspQ.push_back(e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      mem[i] = $urandom;
      refMem[i] = mem[i];
    end
    for (int t = 0; t < 16; t++) tagBusy[t] = 0;
    refMem[2] = 32'd10; mem[2] = 32'd10;
    refMem[3] = 32'hFFFF_FFF0; mem[3] = 32'hFFFF_FFF0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(reqReady === 1'b1 && memCmdValid === 1'b0 && respValid === 1'b0, "R12 reset outputs",
        {29'd0, reqReady, memCmdValid, respValid}, 32'h4);
    #2 rstN = 1'b1;

    // R6 / R7 / R8 directed, each on its own word
    pushReq(4'd0, 16'd4,  32'd5,          32'd0, 1'b1);
    pushReq(4'd1, 16'd8,  32'hFFFF_FFFD,  32'd0, 1'b1);
    pushReq(4'd2, 16'd12, 32'd7,          32'd0, 1'b1);
    pushReq(4'd3, 16'd16, 32'h0F0F_0F0F,  32'd0, 1'b0);
    pushReq(4'd4, 16'd20, 32'h8000_0001,  32'd0, 1'b1);
    pushReq(4'd5, 16'd24, 32'hFFFF_FFFF,  32'd0, 1'b0);
    pushReq(4'd6, 16'd28, 32'h1234_5678,  32'd0, 1'b1);
    pushReq(4'd7, 16'd32, 32'hCAFE_0001,  refMem[8], 1'b1);
    pushReq(4'd7, 16'd36, 32'hCAFE_0002,  ~refMem[9], 1'b1);
    pushReq(4'd8, 16'd43, 32'h0000_00A5,  32'd0, 1'b1);
    pushReq(4'd8, 16'd45, 32'h0000_003C,  32'd0, 1'b0);
    drain();
    for (int w = 1; w <= 11; w++)
      chk(mem[w] === refMem[w], (w == 8 || w == 9) ? "R7 compare-exchange result" :
                                (w >= 10) ? "R8 byte store result" : "R6 operation result", mem[w], refMem[w]);

    // R9 same-word burst, returned olds must follow acceptance order
    maxLat = 12;
    for (int k = 1; k <= 4; k++) pushReq(4'd0, 16'd48, 32'(k), 32'd0, 1'b1);
    drain();
    chk(mem[12] === refMem[12], "R9 same-word burst final word", mem[12], refMem[12]);

    // R10 overlap of different-word reads
    maxLat = 25; maxReadsOut = 0;
    pushReq(4'd4, 16'd52, 32'h10, 32'd0, 1'b0);
    pushReq(4'd4, 16'd56, 32'h20, 32'd0, 1'b0);
    pushReq(4'd4, 16'd60, 32'h40, 32'd0, 1'b0);
    pushReq(4'd4, 16'd0,  32'h80, 32'd0, 1'b0);
    drain();
    chk(maxReadsOut >= 2, "R10 overlapping target reads", 32'(maxReadsOut), 32'd2);

    // R1 back-pressure with memory stalled
    maxLat = 6; stallMem = 1;
    for (int k = 0; k < 5; k++) pushReq(4'd0, 16'(k * 4), 32'd1, 32'd0, 1'b0);
    repeat (12) @(negedge clk);
    #2;
    chk(reqReady === 1'b0 && outstanding == 4, "R1 ready low with all slots busy", {31'd0, reqReady}, 32'd0);
    stallMem = 0;
    drain();

    // random mix
    for (int k = 0; k < 300; k++)
      pushReq(4'($urandom % 9), 16'($urandom % 64), $urandom, ($urandom % 2) ? refMem[$urandom % 16] : $urandom, 1'($urandom % 2));
    drain();
    for (int w = 0; w < 16; w++) chk(mem[w] === refMem[w], "R6 random final word", mem[w], refMem[w]);
    chk(nCmd == 2 * nNoRet + 4 * nRet, "R3/R4 total command count", 32'(nCmd), 32'(2 * nNoRet + 4 * nRet));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule